// File: doc/BRIEF.md
# Lockable Interrupt Status Controller

This block is a small group of memory-mapped registers that manages a set of interrupt source bits. It sits behind a simple 32-bit, word-access register bus. For each source it keeps a sticky status flag and a mask flag. It drives one level-sensitive interrupt line, which is high whenever a status flag is set and its mask flag is clear. A hardware event input can set status flags directly. Software can clear status flags, set them, and change the mask only through dedicated ports that act on single bits.

A global write-protect lock comes out of reset engaged. While it is engaged, every register except the lock itself rejects writes. This covers the control register, status clearing, and the enable, disable and trigger ports. Hardware events still set status flags while the lock is engaged. Register offsets: lock 0x00, control 0x04, status 0x08, mask 0x0C, enable 0x10, disable 0x14, trigger 0x18.

Top module: `irq_lock_ctrl`

## Requirements
- R1: After reset, the lock reads 1, control reads 0, status reads 0, every mask bit reads 1, and `irq_o` and `slverr_en_o` are 0.
- R2: Bit 0 of the lock register at offset 0x00 can always be written and reads back. Its other bits read as zero.
- R3: While the lock is 1, writes to control, status, enable, disable and trigger leave control, status and mask unchanged.
- R4: Bit 0 of control at offset 0x04 is read/write when unlocked and drives `slverr_en_o`. Its other bits read as zero.
- R5: Status at offset 0x08 is write-one-to-clear. A 1 in bit i clears status bit i, and a 0 leaves it unchanged.
- R6: Mask at offset 0xC is read-only. A direct write to it has no effect.
- R7: A 1 in bit i written to the enable port at 0x10 clears mask bit i. A 1 written to the disable port at 0x14 sets mask bit i. Both ports read as zero.
- R8: A 1 in bit i written to the trigger port at 0x18 sets status bit i. The port reads as zero.
- R9: `irq_o` equals the OR over all bits of (status AND NOT mask). It reflects each write or event from the cycle after the clock edge that takes it.
- R10: A pulse on `hw_evt[i]` sets status bit i whether or not the lock is engaged. If it coincides with a clear of the same bit, the set wins.
- R11: Only aligned offsets (address bits 1:0 equal to 0) from 0x00 to 0x18 are decoded. Other offsets read as zero, and writes to them change nothing.
- R12: Read data appears on `bus_rdata` in the cycle after the read request. In every cycle without a read it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| hw_evt | input | N_SRC | Hardware event pulses, one per source |
| slverr_en_o | output | 1 | Control bit 0, the error-reporting enable |
| irq_o | output | 1 | Level interrupt output |

## Verification
The hardest state to reach from the ports is a hardware event that lands in the same cycle as a write-one-to-clear of the same bit. Close behind it is an event arriving while the lock is engaged, followed by a clear attempt that must be rejected. Directed sequences first unlock the block, then line the event pulse up with the clearing write in one bus cycle. The lock is then engaged again before another event is issued. A random phase follows that mixes aligned and misaligned offsets, lock toggling and event pulses. A behavioural model is compared against it on every clock.

// File: rtl/irq_lock_pkg.sv
`timescale 1ns/1ps
package irq_lock_pkg;
  localparam int NUM_REGS = 7;
  // register index = byte offset / 4; the order is the address map
  typedef enum int unsigned {
    RI_LOCK = 0,
    RI_CTRL = 1,
    RI_STAT = 2,
    RI_MASK = 3,
    RI_EN   = 4,
    RI_DIS  = 5,
    RI_TRIG = 6
  } reg_idx_e;
endpackage

// File: rtl/irq_lock_decode.sv
`timescale 1ns/1ps
module irq_lock_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 7
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = sel && aligned && (addr[ADDR_W-1:2] == IDX_W'(g));
  end
endmodule

// File: rtl/irq_lock_core.sv
`timescale 1ns/1ps
module irq_lock_core #(
  parameter int N_SRC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic             dis_we,
  input  logic             trig_we,
  input  logic [N_SRC-1:0] wbits,
  input  logic [N_SRC-1:0] evt_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] status_q, status_n;
  logic [N_SRC-1:0] mask_q, mask_n;
  logic             irq_q;

  always_comb begin
    status_n = status_q;
    mask_n   = mask_q;
    if (!lock_i) begin
      if (clr_we)  status_n = status_n & ~wbits;
      if (trig_we) status_n = status_n | wbits;
      if (en_we)   mask_n   = mask_n & ~wbits;
      if (dis_we)  mask_n   = mask_n | wbits;
    end
    status_n = status_n | evt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_q    <= |(status_n & ~mask_n);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  // R3
  lock_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> $stable(mask_q));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & ~mask_q));

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    // R10
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
      evt_i[g] |=> status_q[g]);
    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we && !lock_i && wbits[g] && !evt_i[g]) |=> !status_q[g]);
  end
endmodule

// File: rtl/irq_lock_ctrl.sv
`timescale 1ns/1ps
module irq_lock_ctrl
  import irq_lock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_SRC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  hw_evt,
  output logic              slverr_en_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] we;
  logic                lock_q, ctrl_q;
  logic [N_SRC-1:0]    status, mask;
  logic [DATA_W-1:0]   rdata_n, rdata_q;
  logic                rd;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata;

  irq_lock_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) decode_i (
    .sel  (bus_sel),
    .addr (bus_addr),
    .hit  (hit)
  );

  assign we = hit & {NUM_REGS{bus_wr}};
  assign rd = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b1;
      ctrl_q <= 1'b0;
    end else begin
      if (we[RI_LOCK])            lock_q <= bus_wdata[0];
      if (we[RI_CTRL] && !lock_q) ctrl_q <= bus_wdata[0];
    end
  end

  irq_lock_core #(.N_SRC(N_SRC)) core_i (
    .clk      (clk),
    .rst      (rst),
    .lock_i   (lock_q),
    .clr_we   (we[RI_STAT]),
    .en_we    (we[RI_EN]),
    .dis_we   (we[RI_DIS]),
    .trig_we  (we[RI_TRIG]),
    .wbits    (bus_wdata[N_SRC-1:0]),
    .evt_i    (hw_evt),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_n = '0;
    if (hit[RI_LOCK])      rdata_n = DATA_W'(lock_q);
    else if (hit[RI_CTRL]) rdata_n = DATA_W'(ctrl_q);
    else if (hit[RI_STAT]) rdata_n = DATA_W'(status);
    else if (hit[RI_MASK]) rdata_n = DATA_W'(mask);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd ? rdata_n : '0;
  end

  assign bus_rdata   = rdata_q;
  assign slverr_en_o = ctrl_q;

  // R3
  lock_ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(ctrl_q));

  // R11
  misaligned_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

  // R12
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> bus_rdata == '0);
endmodule

// File: tb/irq_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_lock_ctrl_tb_top;
  localparam int NS = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] hw_evt = '0;
  logic        slverr_en_o;
  logic        irq_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  bit          m_lock = 1'b1;
  bit          m_ctrl = 1'b0;
  bit [NS-1:0] m_stat = '0;
  bit [NS-1:0] m_mask = '1;

  always #5 clk = ~clk;

  irq_lock_ctrl #(.ADDR_W(8), .DATA_W(32), .N_SRC(NS)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_evt(hw_evt), .slverr_en_o(slverr_en_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] model_read(input bit [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a >> 2)
      0: return 32'(m_lock);
      1: return 32'(m_ctrl);
      2: return 32'(m_stat);
      3: return 32'(m_mask);
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle: drive at negedge, model steps at posedge, compare at next negedge
  task automatic cycle(input bit sel, input bit wr, input bit [7:0] a,
                       input bit [31:0] wd, input bit [NS-1:0] evt);
    bit [31:0]   exp_rd;
    bit          n_lock = m_lock;
    bit          n_ctrl = m_ctrl;
    bit [NS-1:0] n_stat = m_stat;
    bit [NS-1:0] n_mask = m_mask;
    int          idx = int'(a >> 2);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; hw_evt = evt;
    exp_rd = (sel && !wr) ? model_read(a) : 32'h0;
    if (sel && wr && a[1:0] == 2'b00) begin
      if (idx == 0) n_lock = wd[0];
      if (!m_lock) begin
        case (idx)
          1: n_ctrl = wd[0];
          2: n_stat = n_stat & ~wd[NS-1:0];
          4: n_mask = n_mask & ~wd[NS-1:0];
          5: n_mask = n_mask | wd[NS-1:0];
          6: n_stat = n_stat | wd[NS-1:0];
          default: ;
        endcase
      end
    end
    n_stat = n_stat | evt;
    @(posedge clk);
    #1;
    m_lock = n_lock; m_ctrl = n_ctrl; m_stat = n_stat; m_mask = n_mask;
    @(negedge clk);
    check("R9 irq_o vs model", 32'(irq_o), 32'(|(m_stat & ~m_mask)));
    check("R4 slverr_en_o vs model", 32'(slverr_en_o), 32'(m_ctrl));
    check("R12 bus_rdata vs model", bus_rdata, exp_rd);
    bus_sel = 1'b0; bus_wr = 1'b0; hw_evt = '0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    cycle(1'b1, 1'b1, a, d, '0);
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
    cycle(1'b1, 1'b0, a, 32'h0, '0);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", 32'(irq_o), 32'h0);
    check("R1 slverr after reset", 32'(slverr_en_o), 32'h0);
    rd(8'h00, 32'h1, "R1 lock reset");
    rd(8'h04, 32'h0, "R1 ctrl reset");
    rd(8'h08, 32'h0, "R1 status reset");
    rd(8'h0C, 32'h1, "R1 mask reset");

    // R3 locked writes are dropped
    wr(8'h04, 32'h1);
    wr(8'h18, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h04, 32'h0, "R3 ctrl locked");
    rd(8'h08, 32'h0, "R3 trigger locked");
    rd(8'h0C, 32'h1, "R3 enable locked");
    check("R3 irq stays low", 32'(irq_o), 32'h0);

    // R2 unlock
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, 32'h0, "R2 lock cleared");

    // R4 control
    wr(8'h04, 32'hFFFF_FFFF);
    check("R4 slverr set", 32'(slverr_en_o), 32'h1);
    rd(8'h04, 32'h1, "R4 ctrl readback");

    // R8 trigger while masked
    wr(8'h18, 32'h1);
    rd(8'h08, 32'h1, "R8 trigger sets status");
    check("R9 masked irq low", 32'(irq_o), 32'h0);
    rd(8'h18, 32'h0, "R8 trigger reads zero");

    // R7 enable
    wr(8'h10, 32'h1);
    check("R9 irq high when unmasked", 32'(irq_o), 32'h1);
    rd(8'h0C, 32'h0, "R7 enable clears mask");
    rd(8'h10, 32'h0, "R7 enable reads zero");
    rd(8'h14, 32'h0, "R7 disable reads zero");

    // R6 mask direct write
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h0, "R6 mask read-only");

    // R5 w1c
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h1, "R5 write zero keeps status");
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h0, "R5 write one clears status");
    check("R9 irq low after clear", 32'(irq_o), 32'h0);

    // R10 hardware event and priority over clear
    cycle(1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
    check("R10 event raises irq", 32'(irq_o), 32'h1);
    cycle(1'b1, 1'b1, 8'h08, 32'h1, 1'b1);
    rd(8'h08, 32'h1, "R10 set beats clear");

    // R3/R10 locked behaviour
    wr(8'h08, 32'h1);
    wr(8'h00, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h08, 32'h0, "R3 trigger locked");
    wr(8'h14, 32'h1);
    rd(8'h0C, 32'h0, "R3 disable locked");
    cycle(1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
    rd(8'h08, 32'h1, "R10 event while locked");
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h1, "R3 clear locked");
    check("R9 irq held while locked", 32'(irq_o), 32'h1);

    // R7 disable
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h1);
    rd(8'h0C, 32'h1, "R7 disable sets mask");
    check("R9 irq low when masked", 32'(irq_o), 32'h0);

    // R11 unmapped / misaligned
    rd(8'h01, 32'h0, "R11 misaligned read");
    rd(8'h1C, 32'h0, "R11 unmapped read");
    rd(8'h40, 32'h0, "R11 far read");
    wr(8'h11, 32'h1);
    rd(8'h0C, 32'h1, "R11 misaligned enable ignored");
    wr(8'h02, 32'h1);
    rd(8'h00, 32'h0, "R11 misaligned lock ignored");

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      bit [7:0] a = 8'($urandom_range(0, 31));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom,
            NS'($urandom_range(0, 6) == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end
endmodule